// File: doc/BRIEF.md
# Half-Duplex Radio Link Serial Controller

This block sits between a message buffer and a half-duplex radio modem that is reached over an asynchronous serial line. It decodes characters arriving on the receive line. A start marker `*` (0x2A) arms it, and it then collects the characters that follow into a local buffer. The end-of-message control value 0x08 disarms it. The stored message is then sent back over the transmit line. While it sends, the controller keys the radio's push-to-talk output, so the modem turns from its resting receive state to transmit and back.

Receive framing uses 16x oversampling with a sample taken at mid-bit. A start edge that has gone high again by mid-bit is rejected as noise. Characters with a bad parity or stop bit are flagged and dropped. A message longer than the buffer is cut short and an overflow is flagged. Push-to-talk goes high a programmable number of bit times before the first echoed start bit and falls a programmable number of bit times after the last stop bit. The transmit line is held at idle whenever push-to-talk is low. The buffer contents can be read at any time through an address/data port.

Top module: `radio_link_ctrl`

## Requirements
- R1: After reset, tx_o is 1, ptt_o is 0, armed_o is 0, msg_len_o is 0, and parity_err_o and overflow_o are 0.
- R2: A character is 1 start bit (0), 8 data bits LSB first, 1 parity bit and 1 stop bit (1). Each bit lasts 16 ticks of CLKS_PER_TICK clocks, so the default of 814 at 125 MHz gives 9600 baud. Each bit is sampled at its middle.
- R3: While disarmed, every character is discarded except 0x2A. Receiving 0x2A sets armed_o, clears msg_len_o to 0 and clears parity_err_o and overflow_o.
- R4: While armed, 0x08 clears armed_o and is not stored. Any other value, 0x2A included, is written at address msg_len_o, after which msg_len_o increments. The value can be read back on rd_data_o when rd_addr_i holds that address.
- R5: A character whose parity bit fails the odd-parity check (data plus parity has an odd count of ones when correct), or whose stop bit samples 0, sets parity_err_o and is neither stored nor treated as a marker. After a 0 stop bit, the receiver waits for the line to return high before it looks for a new start bit.
- R6: When msg_len_o equals BUF_DEPTH, further data characters are dropped and overflow_o is set. msg_len_o stays at BUF_DEPTH.
- R7: When a message of length N>0 ends, the N stored characters are transmitted in order on tx_o. Each uses the frame of R2, with the parity bit set so that the count of ones is odd.
- R8: ptt_o rises PTT_LEAD_BITS bit times before the first echoed start bit. It falls PTT_TAIL_BITS bit times after the end of the last echoed stop bit.
- R9: tx_o is 1 whenever ptt_o is 0.
- R10: Characters that arrive while ptt_o is high are discarded entirely, 0x2A included.
- R11: An end marker with msg_len_o equal to 0 causes no keying: ptt_o stays 0.
- R12: A low pulse on rx_i that is high again by mid-bit of the start bit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line from the modem |
| tx_o | output | 1 | Serial transmit line to the modem, gated by ptt_o |
| ptt_o | output | 1 | Push-to-talk: 0 receive, 1 transmit |
| rd_addr_i | input | $clog2(BUF_DEPTH) | Buffer read address |
| rd_data_o | output | 8 | Buffer byte at rd_addr_i |
| msg_len_o | output | $clog2(BUF_DEPTH+1) | Number of stored characters |
| armed_o | output | 1 | Start marker seen, message in progress |
| parity_err_o | output | 1 | Parity or stop-bit error seen since arming |
| overflow_o | output | 1 | Characters dropped for lack of space since arming |

## Verification
The bench targets the marker rules at their edges:
- an end marker sent before any start marker, which a design that stored regardless would echo;
- a `*` inside a message, which must be stored rather than restart the message;
- a `*` sent during an echo, which a design that still listened would use to re-arm and clobber the buffer.

It also covers the following cases:
- Bad parity and bad stop frames. A design that ignored the stop bit would store garbage, and a design without the wait for a high line would decode a phantom 0xFF.
- A message two characters longer than the buffer. Without the capacity check, the write address would wrap.
- A short noise pulse, which a design without the mid-bit start check would turn into a character.

On the transmit side, the bench measures the keying lead and tail in clocks, checks that the gated line stays high while unkeyed, and decodes every echoed frame, parity included, across a sweep of byte values.

// File: rtl/rl_link_pkg.sv
package rl_link_pkg;

  localparam logic [7:0] MARK_OPEN  = 8'h2A;
  localparam logic [7:0] MARK_CLOSE = 8'h08;
  localparam int unsigned TICKS_PER_BIT = 16;

  typedef enum logic [2:0] {
    RXS_IDLE, RXS_START, RXS_DATA, RXS_PAR, RXS_STOP, RXS_BREAK
  } rx_state_e;

  typedef enum logic [2:0] {
    ECS_IDLE, ECS_LEAD, ECS_SEND, ECS_WAIT, ECS_TAIL
  } echo_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       par_bad;
    logic       stop_bad;
  } rx_char_t;

endpackage

// File: rtl/rl_tick_gen.sv
module rl_tick_gen #(
  parameter int unsigned CLKS_PER_TICK = 814
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    if (cnt_q == CW'(CLKS_PER_TICK - 1)) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + CW'(1);
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/rl_uart_rx.sv
module rl_uart_rx
  import rl_link_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  logic     rx_i,
  output logic     valid_o,
  output rx_char_t char_o
);
  logic       sync1_q, sync2_q;
  rx_state_e  st_q, st_d;
  logic [3:0] tcnt_q, tcnt_d;
  logic [2:0] bidx_q, bidx_d;
  logic [7:0] shreg_q, shreg_d;
  logic       par_q, par_d;
  logic       valid_q, valid_d;
  rx_char_t   char_q, char_d;
  logic       mid_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= rx_i;
      sync2_q <= sync1_q;
    end
  end

  assign mid_bit = tick_i && (tcnt_q == 4'd15);

  always_comb begin
    st_d    = st_q;
    tcnt_d  = tcnt_q;
    bidx_d  = bidx_q;
    shreg_d = shreg_q;
    par_d   = par_q;
    valid_d = 1'b0;
    char_d  = char_q;
    unique case (st_q)
      RXS_IDLE: begin
        if (!sync2_q) begin
          st_d   = RXS_START;
          tcnt_d = '0;
        end
      end
      RXS_START: begin
        if (tick_i) begin
          if (tcnt_q == 4'd7) begin
            tcnt_d = '0;
            bidx_d = '0;
            st_d   = sync2_q ? RXS_IDLE : RXS_DATA;
          end else begin
            tcnt_d = tcnt_q + 4'd1;
          end
        end
      end
      RXS_DATA: begin
        if (tick_i) tcnt_d = tcnt_q + 4'd1;
        if (mid_bit) begin
          shreg_d = {sync2_q, shreg_q[7:1]};
          if (bidx_q == 3'd7) st_d = RXS_PAR;
          else bidx_d = bidx_q + 3'd1;
        end
      end
      RXS_PAR: begin
        if (tick_i) tcnt_d = tcnt_q + 4'd1;
        if (mid_bit) begin
          par_d = sync2_q;
          st_d  = RXS_STOP;
        end
      end
      RXS_STOP: begin
        if (tick_i) tcnt_d = tcnt_q + 4'd1;
        if (mid_bit) begin
          valid_d         = 1'b1;
          char_d.data     = shreg_q;
          char_d.par_bad  = ~(^{shreg_q, par_q});
          char_d.stop_bad = ~sync2_q;
          st_d            = sync2_q ? RXS_IDLE : RXS_BREAK;
        end
      end
      RXS_BREAK: begin
        if (sync2_q) st_d = RXS_IDLE;
      end
      default: st_d = RXS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RXS_IDLE;
      tcnt_q  <= '0;
      bidx_q  <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      valid_q <= 1'b0;
      char_q  <= '0;
    end else begin
      st_q    <= st_d;
      tcnt_q  <= tcnt_d;
      bidx_q  <= bidx_d;
      shreg_q <= shreg_d;
      par_q   <= par_d;
      valid_q <= valid_d;
      char_q  <= char_d;
    end
  end

  assign valid_o = valid_q;
  assign char_o  = char_q;
endmodule

// File: rtl/rl_uart_tx.sv
module rl_uart_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       start_i,
  input  logic [7:0] data_i,
  output logic       txd_o,
  output logic       done_o
);
  localparam int unsigned FRAME_BITS = 11;

  logic                  active_q, active_d;
  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic [3:0]            tcnt_q, tcnt_d;
  logic [3:0]            bcnt_q, bcnt_d;
  logic                  done_q, done_d;

  always_comb begin
    active_d = active_q;
    frame_d  = frame_q;
    tcnt_d   = tcnt_q;
    bcnt_d   = bcnt_q;
    done_d   = 1'b0;
    if (!active_q) begin
      if (start_i) begin
        active_d = 1'b1;
        frame_d  = {1'b1, ~(^data_i), data_i, 1'b0};
        tcnt_d   = '0;
        bcnt_d   = '0;
      end
    end else if (tick_i) begin
      if (tcnt_q == 4'd15) begin
        tcnt_d = '0;
        if (bcnt_q == 4'(FRAME_BITS - 1)) begin
          active_d = 1'b0;
          done_d   = 1'b1;
        end else begin
          bcnt_d  = bcnt_q + 4'd1;
          frame_d = {1'b1, frame_q[FRAME_BITS-1:1]};
        end
      end else begin
        tcnt_d = tcnt_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      frame_q  <= '1;
      tcnt_q   <= '0;
      bcnt_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      frame_q  <= frame_d;
      tcnt_q   <= tcnt_d;
      bcnt_q   <= bcnt_d;
      done_q   <= done_d;
    end
  end

  assign txd_o  = active_q ? frame_q[0] : 1'b1;
  assign done_o = done_q;
endmodule

// File: rtl/rl_msg_store.sv
module rl_msg_store
  import rl_link_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  rx_char_t      char_i,
  input  logic          echo_busy_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [AW-1:0] echo_addr_i,
  output logic [7:0]    rd_data_o,
  output logic [7:0]    echo_data_o,
  output logic [LW-1:0] len_o,
  output logic          armed_o,
  output logic          perr_o,
  output logic          ovf_o,
  output logic          done_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [LW-1:0] len_q, len_d;
  logic          armed_q, armed_d;
  logic          perr_q, perr_d;
  logic          ovf_q, ovf_d;
  logic          done_q, done_d;
  logic          wr_en;
  logic          accept;

  assign accept = valid_i && !echo_busy_i;

  always_comb begin
    len_d   = len_q;
    armed_d = armed_q;
    perr_d  = perr_q;
    ovf_d   = ovf_q;
    done_d  = 1'b0;
    wr_en   = 1'b0;
    if (accept) begin
      if (char_i.par_bad || char_i.stop_bad) begin
        perr_d = 1'b1;
      end else if (!armed_q) begin
        if (char_i.data == MARK_OPEN) begin
          armed_d = 1'b1;
          len_d   = '0;
          perr_d  = 1'b0;
          ovf_d   = 1'b0;
        end
      end else if (char_i.data == MARK_CLOSE) begin
        armed_d = 1'b0;
        done_d  = 1'b1;
      end else if (len_q == LW'(DEPTH)) begin
        ovf_d = 1'b1;
      end else begin
        wr_en = 1'b1;
        len_d = len_q + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      armed_q <= 1'b0;
      perr_q  <= 1'b0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      len_q   <= len_d;
      armed_q <= armed_d;
      perr_q  <= perr_d;
      ovf_q   <= ovf_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[len_q[AW-1:0]] <= char_i.data;
  end

  assign rd_data_o   = mem_q[rd_addr_i];
  assign echo_data_o = mem_q[echo_addr_i];
  assign len_o       = len_q;
  assign armed_o     = armed_q;
  assign perr_o      = perr_q;
  assign ovf_o       = ovf_q;
  assign done_o      = done_q;
endmodule

// File: rtl/rl_echo_ctrl.sv
module rl_echo_ctrl
  import rl_link_pkg::*;
#(
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned LEAD_BITS = 2,
  parameter int unsigned TAIL_BITS = 1,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1),
  localparam int unsigned LEAD_TICKS = LEAD_BITS * TICKS_PER_BIT,
  localparam int unsigned TAIL_TICKS = TAIL_BITS * TICKS_PER_BIT,
  localparam int unsigned MAX_TICKS = (LEAD_TICKS > TAIL_TICKS) ? LEAD_TICKS : TAIL_TICKS,
  localparam int unsigned CW = $clog2(MAX_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          msg_done_i,
  input  logic [LW-1:0] msg_len_i,
  input  logic          tx_done_i,
  output logic          tx_start_o,
  output logic [AW-1:0] echo_addr_o,
  output logic          ptt_o
);
  echo_state_e   st_q, st_d;
  logic [LW-1:0] idx_q, idx_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ECS_IDLE: begin
        if (msg_done_i && (msg_len_i != '0)) begin
          st_d  = ECS_LEAD;
          idx_d = '0;
          cnt_d = '0;
        end
      end
      ECS_LEAD: begin
        if (tick_i) begin
          if (cnt_q == CW'(LEAD_TICKS - 1)) st_d = ECS_SEND;
          else cnt_d = cnt_q + CW'(1);
        end
      end
      ECS_SEND: st_d = ECS_WAIT;
      ECS_WAIT: begin
        if (tx_done_i) begin
          if (idx_q == msg_len_i - LW'(1)) begin
            st_d  = ECS_TAIL;
            cnt_d = '0;
          end else begin
            idx_d = idx_q + LW'(1);
            st_d  = ECS_SEND;
          end
        end
      end
      ECS_TAIL: begin
        if (tick_i) begin
          if (cnt_q == CW'(TAIL_TICKS - 1)) st_d = ECS_IDLE;
          else cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = ECS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ECS_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
    end
  end

  assign tx_start_o  = (st_q == ECS_SEND);
  assign echo_addr_o = idx_q[AW-1:0];
  assign ptt_o       = (st_q != ECS_IDLE);
endmodule

// File: rtl/radio_link_ctrl.sv
module radio_link_ctrl
  import rl_link_pkg::*;
#(
  parameter int unsigned CLKS_PER_TICK = 814,
  parameter int unsigned BUF_DEPTH     = 64,
  parameter int unsigned PTT_LEAD_BITS = 2,
  parameter int unsigned PTT_TAIL_BITS = 1,
  localparam int unsigned AW = $clog2(BUF_DEPTH),
  localparam int unsigned LW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  output logic          tx_o,
  output logic          ptt_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic [LW-1:0] msg_len_o,
  output logic          armed_o,
  output logic          parity_err_o,
  output logic          overflow_o
);
  logic          rst_s1_q, rst_s2_q;
  logic          rst_core_n;
  logic          tick;
  logic          rx_valid;
  rx_char_t      rx_char;
  logic          msg_done;
  logic [LW-1:0] msg_len;
  logic [AW-1:0] echo_addr;
  logic [7:0]    echo_data;
  logic          tx_start;
  logic          tx_done;
  logic          txd;
  logic          ptt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_core_n = rst_s2_q;

  rl_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_core_n), .tick_o(tick)
  );

  rl_uart_rx u_rx (
    .clk(clk), .rst_n(rst_core_n), .tick_i(tick), .rx_i(rx_i),
    .valid_o(rx_valid), .char_o(rx_char)
  );

  rl_msg_store #(.DEPTH(BUF_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_core_n), .valid_i(rx_valid), .char_i(rx_char),
    .echo_busy_i(ptt), .rd_addr_i(rd_addr_i), .echo_addr_i(echo_addr),
    .rd_data_o(rd_data_o), .echo_data_o(echo_data), .len_o(msg_len),
    .armed_o(armed_o), .perr_o(parity_err_o), .ovf_o(overflow_o),
    .done_o(msg_done)
  );

  rl_echo_ctrl #(
    .DEPTH(BUF_DEPTH), .LEAD_BITS(PTT_LEAD_BITS), .TAIL_BITS(PTT_TAIL_BITS)
  ) u_echo (
    .clk(clk), .rst_n(rst_core_n), .tick_i(tick), .msg_done_i(msg_done),
    .msg_len_i(msg_len), .tx_done_i(tx_done), .tx_start_o(tx_start),
    .echo_addr_o(echo_addr), .ptt_o(ptt)
  );

  rl_uart_tx u_tx (
    .clk(clk), .rst_n(rst_core_n), .tick_i(tick), .start_i(tx_start),
    .data_i(echo_data), .txd_o(txd), .done_o(tx_done)
  );

  assign tx_o      = ptt ? txd : 1'b1;
  assign ptt_o     = ptt;
  assign msg_len_o = msg_len;
endmodule

// File: rtl/rl_link_chk.sv
module rl_link_chk #(
  parameter int unsigned BUF_DEPTH = 64,
  localparam int unsigned LW = $clog2(BUF_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_o,
  input logic          ptt_o,
  input logic [LW-1:0] msg_len_o,
  input logic          armed_o,
  input logic          parity_err_o,
  input logic          overflow_o
);
  // R9
  tx_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ptt_o |-> tx_o);

  // R8
  key_up_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ptt_o) |-> tx_o);

  // R8
  key_down_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ptt_o) |-> tx_o);

  // R6
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_len_o <= LW'(BUF_DEPTH));

  // R6
  ovf_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow_o) |-> (msg_len_o == LW'(BUF_DEPTH)));

  // R5
  err_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parity_err_o) |-> $stable(msg_len_o));

  // R10
  deaf_while_keyed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptt_o |-> !armed_o);
endmodule

bind radio_link_ctrl rl_link_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_o(tx_o), .ptt_o(ptt_o),
  .msg_len_o(msg_len_o), .armed_o(armed_o),
  .parity_err_o(parity_err_o), .overflow_o(overflow_o)
);

// File: tb/radio_link_ctrl_tb.sv
module radio_link_ctrl_tb;
  localparam int CPT   = 2;
  localparam int DEPTH = 8;
  localparam int LEAD  = 2;
  localparam int TAIL  = 1;
  localparam int BITC  = CPT * 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx;
  logic          tx_o, ptt_o, armed_o, parity_err_o, overflow_o;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic [LW-1:0] msg_len;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int t_rise = 0, t_fall = 0, t_first = 0, t_last = 0;
  int rises = 0, gate_viol = 0, frame_bad = 0;
  int mon_cnt = 0;
  logic [7:0] mon_byte [32];
  logic [7:0] exp_b [16];
  int exp_n;

  always #4 clk = ~clk;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && !ptt_o && !tx_o) gate_viol <= gate_viol + 1;
  end

  radio_link_ctrl #(
    .CLKS_PER_TICK(CPT), .BUF_DEPTH(DEPTH),
    .PTT_LEAD_BITS(LEAD), .PTT_TAIL_BITS(TAIL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_o(tx_o), .ptt_o(ptt_o),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .msg_len_o(msg_len),
    .armed_o(armed_o), .parity_err_o(parity_err_o), .overflow_o(overflow_o)
  );

  initial forever begin
    @(posedge ptt_o);
    t_rise = cyc;
    rises++;
  end
  initial forever begin
    @(negedge ptt_o);
    t_fall = cyc;
  end

  initial forever begin
    logic [10:0] fr;
    @(negedge tx_o);
    if (mon_cnt == 0) t_first = cyc;
    t_last = cyc;
    repeat (BITC / 2) @(negedge clk);
    for (int b = 0; b < 11; b++) begin
      fr[b] = tx_o;
      if (b < 10) repeat (BITC) @(negedge clk);
    end
    if (fr[0] != 1'b0 || fr[10] != 1'b1 || (^fr[9:1]) != 1'b1) frame_bad++;
    if (mon_cnt < 32) mon_byte[mon_cnt] = fr[8:1];
    mon_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic send_char(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    @(negedge clk);
    rx = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (BITC) @(negedge clk);
    end
    rx = (~(^d)) ^ bad_par;
    repeat (BITC) @(negedge clk);
    rx = ~bad_stop;
    repeat (BITC) @(negedge clk);
    rx = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic wait_echo();
    int n = 0;
    while (!ptt_o && n < 2000) begin @(negedge clk); n++; end
    while (ptt_o && n < 40000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_store(input string req);
    chk(msg_len == LW'(exp_n), req, int'(msg_len), exp_n);
    for (int i = 0; i < exp_n && i < DEPTH; i++) begin
      rd_addr = AW'(i);
      #1;
      chk(rd_data == exp_b[i], req, int'(rd_data), int'(exp_b[i]));
    end
  endtask

  task automatic check_echo(input int n, input string req);
    chk(mon_cnt == n, req, mon_cnt, n);
    for (int i = 0; i < n && i < 16; i++)
      chk(mon_byte[i] == exp_b[i], req, int'(mon_byte[i]), int'(exp_b[i]));
    chk(frame_bad == 0, "R7 frame", frame_bad, 0);
    chk((t_first - t_rise) >= LEAD * BITC - 4 && (t_first - t_rise) <= LEAD * BITC + 6,
        "R8 lead", t_first - t_rise, LEAD * BITC);
    chk((t_fall - t_last - 11 * BITC) >= TAIL * BITC - 4 &&
        (t_fall - t_last - 11 * BITC) <= TAIL * BITC + 6,
        "R8 tail", t_fall - t_last - 11 * BITC, TAIL * BITC);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int r0;
    rst_n = 1'b0;
    rx = 1'b1;
    rd_addr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(tx_o == 1'b1, "R1 tx", int'(tx_o), 1);
    chk(ptt_o == 1'b0, "R1 ptt", int'(ptt_o), 0);
    chk(armed_o == 1'b0, "R1 armed", int'(armed_o), 0);
    chk(msg_len == '0, "R1 len", int'(msg_len), 0);
    chk(!parity_err_o && !overflow_o, "R1 flags", int'({parity_err_o, overflow_o}), 0);

    // R3 characters before the start marker are discarded
    send_char(8'h41, 0, 0);
    send_char(8'h08, 0, 0);
    repeat (200) @(negedge clk);
    chk(armed_o == 1'b0 && msg_len == '0, "R3 disarmed", int'(msg_len), 0);
    chk(rises == 0, "R3 no echo", rises, 0);
    send_char(8'h2A, 0, 0);
    chk(armed_o == 1'b1, "R3 arm", int'(armed_o), 1);

    // R12 short low pulse ignored
    rx = 1'b0;
    repeat (6) @(negedge clk);
    rx = 1'b1;
    repeat (20 * BITC) @(negedge clk);
    chk(msg_len == '0 && !parity_err_o, "R12 glitch", int'(msg_len), 0);

    // R2 R4 storage, '*' inside a message is data
    exp_b[0] = 8'h00; exp_b[1] = 8'hFF; exp_b[2] = 8'h55;
    exp_b[3] = 8'hAA; exp_b[4] = 8'h2A; exp_b[5] = 8'h01;
    exp_n = 6;
    for (int i = 0; i < 6; i++) send_char(exp_b[i], 0, 0);
    check_store("R4 store");
    chk(armed_o == 1'b1, "R4 still armed", int'(armed_o), 1);
    mon_cnt = 0; frame_bad = 0;
    send_char(8'h08, 0, 0);
    chk(armed_o == 1'b0 && msg_len == LW'(6), "R4 end", int'(armed_o), 0);
    wait_echo();
    check_echo(6, "R7 echo");

    // R5 parity and stop errors
    send_char(8'h2A, 0, 0);
    send_char(8'h31, 1, 0);
    chk(parity_err_o == 1'b1 && msg_len == '0, "R5 parity", int'(msg_len), 0);
    send_char(8'h32, 0, 1);
    repeat (4 * BITC) @(negedge clk);
    chk(msg_len == '0, "R5 stop", int'(msg_len), 0);
    send_char(8'h33, 0, 0);
    exp_b[0] = 8'h33; exp_n = 1;
    check_store("R5 recover");
    mon_cnt = 0; frame_bad = 0;
    send_char(8'h08, 0, 0);
    wait_echo();
    check_echo(1, "R7 single");

    // R6 overflow; R3 flags cleared on arm
    send_char(8'h2A, 0, 0);
    chk(!parity_err_o && !overflow_o, "R3 clear", int'(parity_err_o), 0);
    for (int i = 0; i < DEPTH + 2; i++) begin
      if (i < 16) exp_b[i] = 8'(8'h40 + i);
      send_char(8'(8'h40 + i), 0, 0);
    end
    exp_n = DEPTH;
    chk(overflow_o == 1'b1, "R6 ovf", int'(overflow_o), 1);
    check_store("R6 kept");
    mon_cnt = 0; frame_bad = 0;
    send_char(8'h08, 0, 0);
    wait_echo();
    check_echo(DEPTH, "R6 echo");

    // R11 empty message
    r0 = rises;
    send_char(8'h2A, 0, 0);
    send_char(8'h08, 0, 0);
    repeat (40 * BITC) @(negedge clk);
    chk(rises == r0 && ptt_o == 1'b0, "R11 no key", rises - r0, 0);

    // R10 input during echo discarded
    send_char(8'h2A, 0, 0);
    for (int i = 0; i < 3; i++) begin
      exp_b[i] = 8'(8'h61 + i);
      send_char(exp_b[i], 0, 0);
    end
    exp_n = 3;
    mon_cnt = 0; frame_bad = 0;
    send_char(8'h08, 0, 0);
    if (!ptt_o) @(posedge ptt_o);
    send_char(8'h2A, 0, 0);
    chk(ptt_o == 1'b1, "R10 still keyed", int'(ptt_o), 1);
    wait_echo();
    chk(armed_o == 1'b0, "R10 not armed", int'(armed_o), 0);
    check_store("R10 buffer");
    check_echo(3, "R10 echo");

    // R2 R7 value sweep
    for (int m = 0; m < 4; m++) begin
      send_char(8'h2A, 0, 0);
      for (int i = 0; i < 7; i++) begin
        logic [7:0] v;
        v = 8'((m * 71 + i * 37 + 3) & 255);
        if (v == 8'h08) v = 8'h09;
        exp_b[i] = v;
        send_char(v, 0, 0);
      end
      exp_n = 7;
      check_store("R2 sweep");
      mon_cnt = 0; frame_bad = 0;
      send_char(8'h08, 0, 0);
      wait_echo();
      check_echo(7, "R7 sweep");
    end

    // R9 gating over the whole run
    chk(gate_viol == 0, "R9 gate", gate_viol, 0);
    finish_run();
  end
endmodule